// File: doc/BRIEF.md
# Single-Wire ROM Identity Responder

This block is the device side of a single-wire, open-drain serial bus that runs at standard speed. Every transfer on the bus starts when the host pulls the shared line low. The block takes in a raw copy of the line and gives out one enable that an external open-drain pad uses to pull the line low. It decodes everything by measuring how long each low phase lasts, using a counter that runs on the system clock. All timing limits are parameters counted in clock cycles.

A long low phase is a bus reset. When the line is released after one, the block replies with a presence pulse and then takes in an eight-bit command. Only the identity-read command (0x33) is served. For that command the block sends out a fixed 64-bit identifier, one bit for each host read slot. When the last bit has gone out, it raises a one-cycle completion flag and returns to idle. Any other command makes the block go silent until the next reset.

The controller has six states:
- `ST_IDLE`: waits for a reset.
- `ST_PRES`: drives the presence pulse.
- `ST_CMD`: collects the command bits.
- `ST_TXW`: waits for the host's read-slot edge.
- `ST_TXL`: holds the line low to send a 0.
- `ST_MUTE`: stays silent after an unknown command.

Its transitions are:
- reset-detect: any state except `ST_PRES`, to `ST_PRES`.
- presence-done: `ST_PRES` to `ST_CMD`.
- cmd-match: `ST_CMD` to `ST_TXW`.
- cmd-reject: `ST_CMD` to `ST_MUTE`.
- slot-zero: `ST_TXW` to `ST_TXL`.
- slot-one-advance: `ST_TXW` to `ST_TXW`.
- zero-done: `ST_TXL` to `ST_TXW`.
- last-bit: `ST_TXW` or `ST_TXL` to `ST_IDLE`.

Top module: `owire_rom_slave`

## Requirements
- R1: A low phase of at least `RST_MIN` cycles on the synchronized line, followed by a release, is a bus reset. A low phase shorter than `RST_MIN` seen in idle gets no reply.
- R2: After a bus reset, `bus_pull` is high for exactly `PRES_LEN` consecutive cycles, starting after the host releases the line. It never goes high while the host is still holding the reset low.
- R3: Command bits arrive least significant bit first. A host low phase shorter than `BIT_SPLIT` cycles is a 1, and a longer one is a 0. Eight bits make one command, so 0xCC is not taken as 0x33.
- R4: After command 0x33, each falling edge from the host sends one identifier bit. For a 0, `bus_pull` is held high for `TX0_LEN` cycles. For a 1, the line is left released.
- R5: The identifier bytes go out in the order 0x01, 0x04, 0x79, 0x7D, 0x09, 0x00, 0x00, 0xC4, with each byte sent least significant bit first. This is bit k of parameter `ROM_ID` for slot k.
- R6: After the 64th bit, `rom_done` is high for exactly one cycle and the block returns to idle. Later read slots get no reply until the next reset.
- R7: Any command other than 0x33 is ignored. The block drives nothing until the next reset.
- R8: A bus reset is honoured in every state, including in the middle of a transfer and while the block is itself pulling the line low.
- R9: A low phase that includes the block's own drive is never decoded as a command bit.
- R10: During and right after reset, `bus_pull` and `rom_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw sampled level of the bus line |
| bus_pull | output | 1 | High to pull the bus line low through an open-drain pad |
| rom_done | output | 1 | One-cycle pulse when an identity transfer completes |

## Verification
Two functions can land on the same low phase: bus-reset detection and the block's own 0-bit drive. The test provokes this by breaking off a transfer at slot 17, where the identifier bit is 0. The host begins its reset low with that slot's falling edge, so the block's 15-cycle pull lies inside the host's reset. The test judges the result by the presence pulse, which must last exactly `PRES_LEN` cycles. It then checks that a fresh identity read returns the first byte correctly.

// File: rtl/owr_pkg.sv
package owr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRES = 3'd1,
        ST_CMD  = 3'd2,
        ST_TXW  = 3'd3,
        ST_TXL  = 3'd4,
        ST_MUTE = 3'd5
    } owr_state_e;

    localparam logic [7:0] CMD_ID_READ = 8'h33;
endpackage

// File: rtl/owr_line_sync.sv
module owr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_fall,
    output logic line_rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_raw};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line_s    = chain_q[STAGES-1];
    assign line_fall = prev_q & ~line_s;
    assign line_rise = ~prev_q & line_s;
endmodule

// File: rtl/owr_low_timer.sv
module owr_low_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic             line_fall,
    input  logic             self_drive,
    output logic [CNT_W-1:0] low_len,
    output logic             tainted
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             taint_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            taint_q <= 1'b0;
        end else if (line_fall) begin
            cnt_q   <= CNT_W'(1);
            taint_q <= self_drive;
        end else if (!line_s) begin
            if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
            if (self_drive) taint_q <= 1'b1;
        end
    end

    assign low_len = cnt_q;
    assign tainted = taint_q | self_drive;
endmodule

// File: rtl/owr_id_source.sv
module owr_id_source #(
    parameter int          ID_BITS = 64,
    parameter logic [63:0] ROM_ID  = 64'hC400_0009_7D79_0401,
    localparam int         IDX_W   = $clog2(ID_BITS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);
    assign id_bit = ROM_ID[idx];
endmodule

// File: rtl/owire_rom_slave.sv
module owire_rom_slave #(
    parameter int          CNT_W     = 16,
    parameter int          RST_MIN   = 256,
    parameter int          PRES_LEN  = 120,
    parameter int          BIT_SPLIT = 30,
    parameter int          TX0_LEN   = 15,
    parameter int          ID_BITS   = 64,
    parameter logic [63:0] ROM_ID    = 64'hC400_0009_7D79_0401
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bus_pull,
    output logic rom_done
);
    import owr_pkg::*;

    localparam int               IDX_W     = $clog2(ID_BITS);
    localparam logic [CNT_W-1:0] RST_C     = CNT_W'(RST_MIN);
    localparam logic [CNT_W-1:0] SPLIT_C   = CNT_W'(BIT_SPLIT);
    localparam logic [CNT_W-1:0] PRES_LAST = CNT_W'(PRES_LEN - 1);
    localparam logic [CNT_W-1:0] TX0_LAST  = CNT_W'(TX0_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(ID_BITS - 1);

    owr_state_e       state_q, state_d;
    logic [CNT_W-1:0] tmr_q, tmr_d;
    logic [2:0]       nbit_q, nbit_d;
    logic [7:0]       cmd_q, cmd_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             done_q, done_d;

    logic             line_s, line_fall, line_rise;
    logic [CNT_W-1:0] low_len;
    logic             low_tainted;
    logic             id_bit;
    logic             rx_bit;
    logic [7:0]       cmd_next;

    owr_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_raw(bus_in),
        .line_s(line_s), .line_fall(line_fall), .line_rise(line_rise)
    );

    owr_low_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .line_fall(line_fall),
        .self_drive(bus_pull), .low_len(low_len), .tainted(low_tainted)
    );

    owr_id_source #(.ID_BITS(ID_BITS), .ROM_ID(ROM_ID)) u_id (
        .idx(idx_q), .id_bit(id_bit)
    );

    assign rx_bit   = (low_len < SPLIT_C);
    assign cmd_next = {rx_bit, cmd_q[7:1]};

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        nbit_d  = nbit_q;
        cmd_d   = cmd_q;
        idx_d   = idx_q;
        done_d  = 1'b0;
        if (line_rise && (low_len >= RST_C) && (state_q != ST_PRES)) begin
            state_d = ST_PRES;          // reset-detect
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_PRES: begin
                    if (tmr_q == PRES_LAST) begin
                        state_d = ST_CMD;   // presence-done
                        nbit_d  = '0;
                        cmd_d   = '0;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                ST_CMD: begin
                    if (line_rise && !low_tainted) begin
                        cmd_d  = cmd_next;
                        nbit_d = nbit_q + 1'b1;
                        if (nbit_q == 3'd7) begin
                            idx_d   = '0;
                            state_d = (cmd_next == CMD_ID_READ) ? ST_TXW : ST_MUTE;
                        end
                    end
                end
                ST_TXW: begin
                    if (line_fall) begin
                        if (!id_bit) begin
                            state_d = ST_TXL;   // slot-zero
                            tmr_d   = '0;
                        end else if (idx_q == IDX_LAST) begin
                            state_d = ST_IDLE;  // last-bit
                            done_d  = 1'b1;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_TXL: begin
                    if (tmr_q == TX0_LAST) begin
                        if (idx_q == IDX_LAST) begin
                            state_d = ST_IDLE;
                            done_d  = 1'b1;
                        end else begin
                            state_d = ST_TXW;   // zero-done
                            idx_d   = idx_q + 1'b1;
                        end
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                ST_MUTE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            nbit_q  <= '0;
            cmd_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            nbit_q  <= nbit_d;
            cmd_q   <= cmd_d;
            idx_q   <= idx_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        bus_pull = (state_q == ST_PRES) || (state_q == ST_TXL);
        rom_done = done_q;
    end
endmodule

// File: rtl/owr_checker.sv
module owr_checker #(
    parameter int PRES_LEN = 120,
    parameter int TX0_LEN  = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_pull,
    input logic                rom_done,
    input logic                line_rise,
    input owr_pkg::owr_state_e state
);
    import owr_pkg::*;

    localparam int MAX_RUN = (PRES_LEN > TX0_LEN) ? PRES_LEN : TX0_LEN;

    logic [15:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= bus_pull ? run_q + 1'b1 : '0;
    end

    a_r2_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(MAX_RUN));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rom_done |=> !rom_done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rom_done |-> (state == ST_IDLE));

    a_r1_presence_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES && $past(state) != ST_PRES) |-> $past(line_rise));

    a_r7_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTE) |=> (state == ST_MUTE || state == ST_PRES));

    a_r4_zero_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXL && $past(state) != ST_TXL) |-> ($past(state) == ST_TXW));
endmodule

bind owire_rom_slave owr_checker #(.PRES_LEN(PRES_LEN), .TX0_LEN(TX0_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_pull(bus_pull), .rom_done(rom_done),
    .line_rise(line_rise), .state(state_q)
);

// File: tb/test_owire_rom_slave.sv
module test_owire_rom_slave;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic bus_pull, rom_done;
    logic line;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [7:0] exp_id [8] = '{8'h01, 8'h04, 8'h79, 8'h7D, 8'h09, 8'h00, 8'h00, 8'hC4};

    always #(CLK_PERIOD/2) clk = ~clk;
    assign line = ~(m_low | bus_pull);

    owire_rom_slave i_owire_rom_slave (
        .clk(clk), .rst_n(rst_n), .bus_in(line),
        .bus_pull(bus_pull), .rom_done(rom_done)
    );

    always @(posedge clk) if (rst_n && rom_done) done_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host reset; returns pull cycles during host low and after release
    task automatic host_reset(input int low_len, output int during, output int after);
        during = 0; after = 0;
        @(negedge clk);
        m_low = 1'b1;
        for (int i = 0; i < low_len; i++) begin @(negedge clk); if (bus_pull) during++; end
        m_low = 1'b0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (bus_pull) after++; end
    endtask

    task automatic write_bit(input bit b);
        @(negedge clk);
        m_low = 1'b1;
        wait_cyc(b ? 5 : 65);
        m_low = 1'b0;
        wait_cyc(10);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output bit b);
        @(negedge clk);
        m_low = 1'b1;
        wait_cyc(2);
        m_low = 1'b0;
        wait_cyc(10);
        b = line;
        wait_cyc(58);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin bit b; read_bit(b); v[i] = b; end
    endtask

    task automatic do_reset_ok(input string req);
        int d, a;
        host_reset(480, d, a);
        check(d == 0, {req, " no pull while host holds reset"}, d, 0);
        check(a == 120, {req, " presence length"}, a, 120);
    endtask

    task automatic t_reset_state();
        check(bus_pull == 1'b0, "R10 bus_pull at reset", bus_pull, 0);
        check(rom_done == 1'b0, "R10 rom_done at reset", rom_done, 0);
    endtask

    task automatic t_short_low();
        int d, a;
        host_reset(200, d, a);
        check(a == 0, "R1 short low gets no presence", a, 0);
    endtask

    task automatic t_full_read();
        logic [7:0] v;
        int d0;
        do_reset_ok("R2");
        write_byte(8'h33);            // R9: presence rise must not count as a bit
        d0 = done_cnt;
        for (int k = 0; k < 8; k++) begin
            read_byte(v);
            check(v == exp_id[k], "R5 R4 id byte", v, exp_id[k]);
        end
        check(done_cnt - d0 == 1, "R6 one completion pulse", done_cnt - d0, 1);
        read_byte(v);
        check(v == 8'hFF, "R6 silent after transfer", v, 8'hFF);
        check(done_cnt - d0 == 1, "R6 no extra pulse", done_cnt - d0, 1);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] v;
        do_reset_ok("R1");
        write_byte(8'hCC);            // mirror of 0x33: proves LSB-first (R3)
        read_byte(v);
        check(v == 8'hFF, "R7 R3 ignored command drives nothing", v, 8'hFF);
        read_byte(v);
        check(v == 8'hFF, "R7 still silent", v, 8'hFF);
    endtask

    task automatic t_reset_mid_tx();
        logic [7:0] v;
        bit b;
        int d, a;
        do_reset_ok("R8");
        write_byte(8'h33);
        for (int i = 0; i < 17; i++) read_bit(b);
        host_reset(480, d, a);        // slot 17 is a 0: own drive inside host reset
        check(a == 120, "R8 presence after reset during own drive", a, 120);
        write_byte(8'h33);
        read_byte(v);
        check(v == 8'h01, "R8 fresh transfer first byte", v, 8'h01);
    endtask

    initial begin
        wait_cyc(5);
        t_reset_state();
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset_state();
        t_short_low();
        t_full_read();
        t_bad_cmd();
        t_reset_mid_tx();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule